// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-side register file of a classic byte-wide UART. A 3-bit address, separate active-high write and read strobes and an 8-bit data bus select one of ten registers: receive buffer, transmit holding, the two divisor bytes, interrupt enable, interrupt identification, line control, modem control, line status and modem status. The block stores the registers and multiplexes read data. It gives the transmitter a load strobe with the byte to send, gives the receiver an acknowledge when its byte is read, and gives the baud generator the 16-bit divisor with a load strobe.

Bit 6 of the line control register selects divisor access. While it is set, the two lowest addresses reach the divisor low and high bytes. While it is clear, they reach the data registers and the interrupt enable register. Status bits follow events from the serial side: byte arrival, line errors, transmitter progress and modem input changes. The interrupt identification register reports the highest-priority enabled source, and `irq` is asserted whenever a source is pending.

Top module: `uart_host_regs`

## Requirements
- R1: When reset ends, every register reads 0x00, except line status, which reads 0x60, and interrupt identification, which reads 0x01. `tx_load`, `rx_ack`, `div_load` and `irq` are low and `divisor` is 0.
- R2: When line-control bit 6 is 1, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. Each such write pulses `div_load` high for the cycle after the write. It does not pulse `tx_load` and it leaves the interrupt enable register unchanged.
- R3: A write to address 0 with line-control bit 6 at 0 sets `tx_data` to the written byte and pulses `tx_load` high for exactly the cycle after the write. It clears line-status bits 5 and 6 and leaves `divisor` unchanged.
- R4: A read of address 0 with line-control bit 6 at 0 returns the receive buffer. It pulses `rx_ack` high for exactly the following cycle and clears line-status bit 0 (data ready).
- R5: A cycle with `rx_valid` high stores `rx_data` in the receive buffer and sets data ready. If data ready was already set and the buffer is not read in that cycle, line-status bit 1 (overrun) is set. If the buffer is read in that same cycle, the read returns the old byte and no overrun is flagged.
- R6: With line-control bit 6 at 0, address 1 holds a 4-bit interrupt enable: bit 0 received data, bit 1 transmit holding empty, bit 2 line error, bit 3 modem change. Bits 7:4 read as 0.
- R7: Address 3 (line control, 8 bits) and address 4 (modem control, bits 4:0; bits 7:5 read 0) are readable and writable whatever the value of bit 6. They drive `line_ctrl` and `modem_ctrl`.
- R8: Writes to addresses 2, 5, 6 and 7 change nothing. Address 7 always reads 0x00.
- R9: Modem status bits 7:4 hold the sampled `modem_in[3:0]`. Bit i of 3:0 is set when `modem_in[i]` changes, and all four bits are cleared by a read of address 6.
- R10: Interrupt identification reads 0x06 for an enabled line error (line-status bits 4:1), else 0x04 for enabled data ready, else 0x02 for enabled transmit holding empty (line-status bit 5), else 0x00 for an enabled modem change, else 0x01. `irq` is the inverse of bit 0 of that value.
- R11: A `tx_taken` pulse sets line-status bit 5 and a `tx_done` pulse sets bit 6. A transmit write in the same cycle wins, and both bits end clear.
- R12: `rx_err[0]`, `rx_err[1]` and `rx_err[2]` set line-status bits 2, 3 and 4. A read of address 5 returns the current value and then clears bits 4:1. An error arriving in the cycle of that read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address |
| rx_data | input | 8 | Byte from the receive shifter |
| rx_valid | input | 1 | Receive shifter has a complete byte |
| rx_err | input | 3 | Parity, framing, break error pulses |
| tx_taken | input | 1 | Transmitter moved the holding byte to its shifter |
| tx_done | input | 1 | Transmitter has gone idle |
| modem_in | input | 4 | Modem status inputs |
| tx_data | output | 8 | Transmit holding byte |
| tx_load | output | 1 | One-cycle pulse: new transmit byte |
| rx_ack | output | 1 | One-cycle pulse: receive byte consumed |
| divisor | output | 16 | Baud divisor |
| div_load | output | 1 | One-cycle pulse: divisor written |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |
| irq | output | 1 | Interrupt pending |

## Verification
The sharpest overlap is a host read of the receive buffer in the same cycle that the receiver delivers a new byte. The bench provokes it by raising `rd_en` at address 0 and `rx_valid` in one cycle. It judges the result by checking that the read returns the previous byte, that `rx_ack` pulses, that the buffer then holds the new byte with data ready set, and that no overrun is flagged. The same-cycle pattern is repeated for an error pulse during a status read and for a transmitter take during a holding write, and register sweeps cover all 256 data values.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int DIV_W    = 16;
  localparam int IER_W    = 4;
  localparam int MCR_W    = 5;
  localparam int MODEM_W  = 4;
  localparam int RXERR_W  = 3;
  localparam int IID_W    = 4;
  localparam int DLAB_BIT = 6;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IID  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSR  = 3'd6;

  typedef enum logic [IID_W-1:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6
  } iid_e;

  typedef struct packed {
    logic thr;
    logic div_lo;
    logic div_hi;
    logic ier;
    logic lcr;
    logic mcr;
  } wsel_t;

  typedef struct packed {
    logic rbr;
    logic lsr;
    logic msr;
  } rsel_t;
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              dlab,
  output wsel_t             wsel,
  output rsel_t             rsel
);
  always_comb begin
    wsel = '0;
    if (wr_en) begin
      case (addr)
        A_DATA: begin
          if (dlab) wsel.div_lo = 1'b1;
          else      wsel.thr    = 1'b1;
        end
        A_IER: begin
          if (dlab) wsel.div_hi = 1'b1;
          else      wsel.ier    = 1'b1;
        end
        A_LCR:   wsel.lcr = 1'b1;
        A_MCR:   wsel.mcr = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rsel = '0;
    if (rd_en) begin
      case (addr)
        A_DATA:  rsel.rbr = ~dlab;
        A_LSR:   rsel.lsr = 1'b1;
        A_MSR:   rsel.msr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_host_line_status.sv
module uart_host_line_status
  import uart_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               rx_valid,
  input  logic [RXERR_W-1:0] rx_err,
  input  logic               tx_taken,
  input  logic               tx_done,
  input  logic               thr_wr,
  input  logic               rbr_rd,
  input  logic               lsr_rd,
  output logic [DATA_W-1:0]  rbr,
  output logic [DATA_W-1:0]  lsr
);
  localparam int ERR_W = RXERR_W + 1;

  logic [DATA_W-1:0] rbr_q;
  logic              dr_q, dr_n;
  logic [ERR_W-1:0]  err_q, err_n;
  logic              thre_q, thre_n;
  logic              temt_q, temt_n;
  logic              overrun_set;

  always_comb begin
    overrun_set = rx_valid & dr_q & ~rbr_rd;
    if (rx_valid)    dr_n = 1'b1;
    else if (rbr_rd) dr_n = 1'b0;
    else             dr_n = dr_q;
    err_n = (lsr_rd ? '0 : err_q) | {rx_err, overrun_set};
    if (thr_wr)        thre_n = 1'b0;
    else if (tx_taken) thre_n = 1'b1;
    else               thre_n = thre_q;
    if (thr_wr)       temt_n = 1'b0;
    else if (tx_done) temt_n = 1'b1;
    else              temt_n = temt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q  <= '0;
      dr_q   <= 1'b0;
      err_q  <= '0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      if (rx_valid) rbr_q <= rx_data;
      dr_q   <= dr_n;
      err_q  <= err_n;
      thre_q <= thre_n;
      temt_q <= temt_n;
    end
  end

  assign rbr = rbr_q;
  assign lsr = {1'b0, temt_q, thre_q, err_q, dr_q};
endmodule

// File: rtl/uart_host_modem_status.sv
module uart_host_modem_status
  import uart_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               msr_rd,
  output logic [DATA_W-1:0]  msr
);
  logic [MODEM_W-1:0] cur_q;
  logic [MODEM_W-1:0] delta_q, delta_n;

  for (genvar i = 0; i < MODEM_W; i++) begin : g_line
    assign delta_n[i] = (delta_q[i] & ~msr_rd) | (modem_in[i] ^ cur_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      delta_q <= '0;
    end else begin
      cur_q   <= modem_in;
      delta_q <= delta_n;
    end
  end

  assign msr = {cur_q, delta_q};
endmodule

// File: rtl/uart_host_irq_ident.sv
module uart_host_irq_ident
  import uart_host_pkg::*;
(
  input  logic [IER_W-1:0] ier,
  input  logic             line_err,
  input  logic             data_ready,
  input  logic             thr_empty,
  input  logic             modem_delta,
  output logic [IID_W-1:0] iid,
  output logic             irq
);
  iid_e code;

  always_comb begin
    if (ier[2] && line_err)         code = IID_LINE;
    else if (ier[0] && data_ready)  code = IID_RXDATA;
    else if (ier[1] && thr_empty)   code = IID_THRE;
    else if (ier[3] && modem_delta) code = IID_MODEM;
    else                            code = IID_NONE;
  end

  assign iid = code;
  assign irq = (code != IID_NONE);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               rx_valid,
  input  logic [RXERR_W-1:0] rx_err,
  input  logic               tx_taken,
  input  logic               tx_done,
  input  logic [MODEM_W-1:0] modem_in,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_load,
  output logic               rx_ack,
  output logic [DIV_W-1:0]   divisor,
  output logic               div_load,
  output logic [DATA_W-1:0]  line_ctrl,
  output logic [MCR_W-1:0]   modem_ctrl,
  output logic               irq
);
  localparam int HALF_DIV = DIV_W / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [IER_W-1:0]    ier_q, ier_n;
  logic [DATA_W-1:0]   lcr_q, lcr_n;
  logic [MCR_W-1:0]    mcr_q, mcr_n;
  logic [HALF_DIV-1:0] dll_q, dll_n;
  logic [HALF_DIV-1:0] dlm_q, dlm_n;
  logic [DATA_W-1:0]   thr_q, thr_n;
  logic                tx_load_q, rx_ack_q, div_load_q;
  logic                dlab;
  wsel_t               wsel;
  rsel_t               rsel;
  logic [DATA_W-1:0]   rbr, lsr, msr;
  logic [IID_W-1:0]    iid;

  assign dlab = lcr_q[DLAB_BIT];

  uart_host_decode u_decode (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .dlab  (dlab),
    .wsel  (wsel),
    .rsel  (rsel)
  );

  uart_host_line_status u_line (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_err   (rx_err),
    .tx_taken (tx_taken),
    .tx_done  (tx_done),
    .thr_wr   (wsel.thr),
    .rbr_rd   (rsel.rbr),
    .lsr_rd   (rsel.lsr),
    .rbr      (rbr),
    .lsr      (lsr)
  );

  uart_host_modem_status u_modem (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .modem_in (modem_in),
    .msr_rd   (rsel.msr),
    .msr      (msr)
  );

  uart_host_irq_ident u_irq (
    .ier         (ier_q),
    .line_err    (|lsr[4:1]),
    .data_ready  (lsr[0]),
    .thr_empty   (lsr[5]),
    .modem_delta (|msr[MODEM_W-1:0]),
    .iid         (iid),
    .irq         (irq)
  );

  // next state with explicit enables
  always_comb begin
    ier_n = wsel.ier    ? wdata[IER_W-1:0]    : ier_q;
    lcr_n = wsel.lcr    ? wdata               : lcr_q;
    mcr_n = wsel.mcr    ? wdata[MCR_W-1:0]    : mcr_q;
    dll_n = wsel.div_lo ? wdata[HALF_DIV-1:0] : dll_q;
    dlm_n = wsel.div_hi ? wdata[HALF_DIV-1:0] : dlm_q;
    thr_n = wsel.thr    ? wdata               : thr_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ier_q      <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      dll_q      <= '0;
      dlm_q      <= '0;
      thr_q      <= '0;
      tx_load_q  <= 1'b0;
      rx_ack_q   <= 1'b0;
      div_load_q <= 1'b0;
    end else begin
      ier_q      <= ier_n;
      lcr_q      <= lcr_n;
      mcr_q      <= mcr_n;
      dll_q      <= dll_n;
      dlm_q      <= dlm_n;
      thr_q      <= thr_n;
      tx_load_q  <= wsel.thr;
      rx_ack_q   <= rsel.rbr;
      div_load_q <= wsel.div_lo | wsel.div_hi;
    end
  end

  // read multiplexer
  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll_q : rbr;
      A_IER:   rdata = dlab ? dlm_q : {{(DATA_W-IER_W){1'b0}}, ier_q};
      A_IID:   rdata = {{(DATA_W-IID_W){1'b0}}, iid};
      A_LCR:   rdata = lcr_q;
      A_MCR:   rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
      A_LSR:   rdata = lsr;
      A_MSR:   rdata = msr;
      default: rdata = '0;
    endcase
  end

  assign tx_data    = thr_q;
  assign tx_load    = tx_load_q;
  assign rx_ack     = rx_ack_q;
  assign divisor    = {dlm_q, dll_q};
  assign div_load   = div_load_q;
  assign line_ctrl  = lcr_q;
  assign modem_ctrl = mcr_q;
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk
  import uart_host_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] line_ctrl,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_load,
  input logic              rx_ack,
  input logic [DIV_W-1:0]  divisor,
  input logic              div_load,
  input logic              irq
);
  logic dlab;
  assign dlab = line_ctrl[DLAB_BIT];

  assert_thr_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_DATA && !dlab) |=> (tx_load && tx_data == $past(wdata)));

  assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_load |=> !tx_load);

  assert_rx_ack_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && addr == A_DATA && !dlab) |=> rx_ack);

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_ack |=> !rx_ack);

  assert_div_low_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_DATA && dlab) |=>
      (div_load && !tx_load && divisor[7:0] == $past(wdata)));

  assert_div_high_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == A_IER && dlab) |=> (div_load && divisor[15:8] == $past(wdata)));

  assert_ier_upper_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr == A_IER && !dlab) |-> rdata[7:4] == 4'h0);

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr == 3'd7) |-> rdata == 8'h00);

  assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr == A_IID) |-> (irq == !rdata[0]));
endmodule

bind uart_host_regs uart_host_regs_chk chk_i (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .line_ctrl  (line_ctrl),
  .tx_data    (tx_data),
  .tx_load    (tx_load),
  .rx_ack     (rx_ack),
  .divisor    (divisor),
  .div_load   (div_load),
  .irq        (irq)
);

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata, rdata;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic [2:0]  rx_err;
  logic        tx_taken, tx_done;
  logic [3:0]  modem_in;
  logic [7:0]  tx_data;
  logic        tx_load, rx_ack;
  logic [15:0] divisor;
  logic        div_load;
  logic [7:0]  line_ctrl;
  logic [4:0]  modem_ctrl;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_err(rx_err), .tx_taken(tx_taken), .tx_done(tx_done), .modem_in(modem_in),
    .tx_data(tx_data), .tx_load(tx_load), .rx_ack(rx_ack), .divisor(divisor),
    .div_load(div_load), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic rx_byte(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rx_valid = 0; rx_err = 0;
    tx_taken = 0; tx_done = 0; modem_in = 0; addr = 0; wdata = 0; rx_data = 0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 reset state
    chk("R1 tx_load", 32'(tx_load), 0);
    chk("R1 rx_ack", 32'(rx_ack), 0);
    chk("R1 div_load", 32'(div_load), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 divisor", 32'(divisor), 0);
    for (int a = 0; a < 8; a++) begin
      if (a == 2)      rd_chk(3'(a), 8'h01, "R1 iid reset");
      else if (a == 5) rd_chk(3'(a), 8'h60, "R1 lsr reset");
      else             rd_chk(3'(a), 8'h00, "R1 reg reset");
    end

    // R7 line control and modem control sweeps
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, 8'(v));
      rd_chk(3'd3, 8'(v), "R7 lcr");
      chk("R7 line_ctrl", 32'(line_ctrl), 32'(v));
      wr(3'd4, 8'(v));
      rd_chk(3'd4, 8'(v & 8'h1f), "R7 mcr");
      chk("R7 modem_ctrl", 32'(modem_ctrl), 32'(v & 5'h1f));
    end
    wr(3'd3, 8'h00);

    // R6 interrupt enable sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v));
      rd_chk(3'd1, 8'(v & 8'h0f), "R6 ier");
    end
    wr(3'd1, 8'h00);

    // R2 divisor overlay
    wr(3'd3, 8'h40);
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      chk("R2 div_load low", 32'(div_load), 1);
      chk("R2 no tx_load", 32'(tx_load), 0);
      wr(3'd1, 8'(~v));
      chk("R2 div_load high", 32'(div_load), 1);
      chk("R2 divisor", 32'(divisor), 32'({8'(~v), 8'(v)}));
      rd_chk(3'd0, 8'(v), "R2 read low");
      rd_chk(3'd1, 8'(~v), "R2 read high");
    end
    chk("R2 div_load drops", 32'(div_load), 0);
    wr(3'd3, 8'h00);
    rd_chk(3'd1, 8'h00, "R2 ier untouched");
    rd_chk(3'd5, 8'h60, "R2 lsr untouched");

    // R3 transmit holding sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      chk("R3 tx_load", 32'(tx_load), 1);
      chk("R3 tx_data", 32'(tx_data), 32'(v));
      idle(1);
      chk("R3 tx_load single", 32'(tx_load), 0);
    end
    chk("R3 divisor kept", 32'(divisor), 32'h00ff);
    rd_chk(3'd5, 8'h00, "R3 lsr after write");

    // R11 transmitter progress
    tx_taken = 1; idle(1); tx_taken = 0;
    rd_chk(3'd5, 8'h20, "R11 thre set");
    tx_done = 1; idle(1); tx_done = 0;
    rd_chk(3'd5, 8'h60, "R11 temt set");
    tx_taken = 1; tx_done = 1;
    wr(3'd0, 8'h77);
    tx_taken = 0; tx_done = 0;
    rd_chk(3'd5, 8'h00, "R11 write wins");
    tx_taken = 1; tx_done = 1; idle(1); tx_taken = 0; tx_done = 0;

    // R5 / R4 receive path and overrun
    do_reset();
    rx_byte(8'h11);
    rd_chk(3'd5, 8'h61, "R5 data ready");
    rx_byte(8'h22);
    rd_chk(3'd5, 8'h63, "R5 overrun");
    rd_chk(3'd5, 8'h61, "R12 lsr read clears");
    rd_chk(3'd0, 8'h22, "R4 rbr data");
    chk("R4 rx_ack", 32'(rx_ack), 1);
    idle(1);
    chk("R4 rx_ack single", 32'(rx_ack), 0);
    rd_chk(3'd5, 8'h60, "R4 dr cleared");

    // same-cycle buffer read and new byte
    rx_byte(8'h33);
    addr = 3'd0; rd_en = 1; rx_data = 8'h44; rx_valid = 1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 0; rx_valid = 0;
    chk("R5 read returns old", 32'(d), 32'h33);
    chk("R4 rx_ack on collision", 32'(rx_ack), 1);
    rd_chk(3'd5, 8'h61, "R5 no overrun on collision");
    rd_chk(3'd0, 8'h44, "R5 new byte kept");

    // R12 error flags, set wins over clear
    rx_err = 3'b101; idle(1); rx_err = 0;
    rd_chk(3'd5, 8'h74, "R12 parity and break");
    rd_chk(3'd5, 8'h60, "R12 cleared");
    rx_err = 3'b111;
    rd_chk(3'd5, 8'h60, "R12 read value");
    rx_err = 0;
    rd_chk(3'd5, 8'h7c, "R12 set wins");
    rd_chk(3'd5, 8'h60, "R12 cleared again");

    // R9 modem status
    modem_in = 4'b1010; idle(1);
    rd_chk(3'd6, 8'haa, "R9 level and delta");
    rd_chk(3'd6, 8'ha0, "R9 delta cleared");
    modem_in = 4'b0000; idle(1);
    rd_chk(3'd6, 8'h0a, "R9 falling delta");
    rd_chk(3'd6, 8'h00, "R9 idle");

    // R10 priority
    do_reset();
    rd_chk(3'd2, 8'h01, "R10 none");
    wr(3'd1, 8'h08);
    rd_chk(3'd2, 8'h01, "R10 thre masked");
    modem_in = 4'b0001; idle(1);
    rd_chk(3'd2, 8'h00, "R10 modem");
    chk("R10 irq modem", 32'(irq), 1);
    wr(3'd1, 8'h0f);
    rd_chk(3'd2, 8'h02, "R10 thre");
    rx_byte(8'h5c);
    rd_chk(3'd2, 8'h04, "R10 rx data");
    rx_err = 3'b001; idle(1); rx_err = 0;
    rd_chk(3'd2, 8'h06, "R10 line");
    rd_chk(3'd5, 8'h65, "R10 lsr content");
    rd_chk(3'd2, 8'h04, "R10 after lsr read");
    rd_chk(3'd0, 8'h5c, "R10 rbr");
    rd_chk(3'd2, 8'h02, "R10 after rbr read");
    wr(3'd0, 8'h01);
    rd_chk(3'd2, 8'h00, "R10 after thr write");
    rd_chk(3'd6, 8'h11, "R10 msr");
    rd_chk(3'd2, 8'h01, "R10 all clear");
    chk("R10 irq low", 32'(irq), 0);
    modem_in = 0;

    // R8 read-only and unused addresses
    do_reset();
    wr(3'd2, 8'hff);
    wr(3'd5, 8'hff);
    wr(3'd6, 8'hff);
    wr(3'd7, 8'hff);
    rd_chk(3'd2, 8'h01, "R8 iid write ignored");
    rd_chk(3'd5, 8'h60, "R8 lsr write ignored");
    rd_chk(3'd6, 8'h00, "R8 msr write ignored");
    rd_chk(3'd7, 8'h00, "R8 unused reads zero");
    for (int a = 0; a < 5; a++) begin
      if (a != 2) rd_chk(3'(a), 8'h00, "R8 other regs untouched");
    end
    chk("R8 divisor untouched", 32'(divisor), 0);
    chk("R8 no tx_load", 32'(tx_load), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule